// File: doc/BRIEF.md
# Dual-Mode Buck Channel Mode and Gate Controller

This block is the digital decision logic of one synchronous step-down channel. It picks between two regimes. The first is constant-frequency pulse-width operation, paced by a per-period tick and a raw comparator. The second is a light-load burst regime, in which the output is held inside a small voltage window. It also produces the high-side and low-side switch enables, with a guaranteed gap between them. Analog sensing is done elsewhere. The block sees only digitised comparator flags: peak current above the light-load fraction, current at the limit, three output-voltage thresholds, inductor current at zero, and soft-start in progress.

Entry into the burst regime is decided on current: a run of consecutive light periods must build up first. Exit is decided on voltage: the output sags below a lower threshold. The block reports the active regime and a select that tells the current-limit circuit to drop to a quarter of its threshold while the burst regime is active. All pins are plain level or pulse control signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `buck_mode_ctrl`

## Requirements
- R1: Reset (rst_n low, asynchronous) places the block in pulse-width mode, with the light-period count cleared, both gates low and ilim_quarter low.
- R2: A period is the interval that ends with a cycle in which pwm_tick is high; that tick cycle belongs to the period. A period is light when pk_above stays low in every cycle of it. In pulse-width mode, the tick that closes the 16th consecutive light period switches mode_psv to 1, visible in the cycle after that tick.
- R3: A period in which pk_above is high clears the light-period count to zero, so fewer than 16 light periods in a row never change the mode.
- R4: While ss_active is high, the count stays cleared and burst mode is never entered. If ss_active rises while in burst mode, mode_psv returns to 0 in the next cycle.
- R5: In burst mode, v_below_lo high returns mode_psv to 0 in the next cycle.
- R6: ilim_quarter is 1 exactly while the block is in burst mode, and 0 in pulse-width mode.
- R7: In pulse-width mode, a tick with pwm_cmp high requests the high side. pwm_cmp falling ends the high-side request and requests the low side. The low-side request ends on i_zero (discontinuous case) or at the next tick (continuous case). A gate follows its request one cycle later, unless it is still waiting out the gap of R8.
- R8: hs_gate and ls_gate are never high together. Each rising edge of either gate comes after at least DEAD_CYC clock cycles in which both gates were low.
- R9: In pulse-width mode, i_lim high ends the high-side pulse: hs_gate is low two cycles later and stays low until the next tick, even while pwm_cmp stays high.
- R10: In burst mode, v_below_nom turns the high side on. It stays on until v_above_hi, after which the low side takes over until i_zero. The high side is then held off until v_below_nom is seen again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_tick | input | 1 | One-cycle pulse at the start of each switching period |
| pwm_cmp | input | 1 | Raw pulse-width comparator, high while the high side should conduct |
| pk_above | input | 1 | Peak high-side current above the light-load fraction of the limit |
| i_lim | input | 1 | High-side current at the programmed limit |
| v_below_nom | input | 1 | Output below its nominal level |
| v_above_hi | input | 1 | Output at least 2% above nominal |
| v_below_lo | input | 1 | Output at least 2% below nominal |
| i_zero | input | 1 | Inductor current has reached zero |
| ss_active | input | 1 | Soft-start in progress |
| hs_gate | output | 1 | High-side switch enable |
| ls_gate | output | 1 | Low-side switch enable |
| mode_psv | output | 1 | 1 while in burst (power-saving) mode, 0 in pulse-width mode |
| ilim_quarter | output | 1 | Selects the quarter current-limit threshold |

## Verification
The bench runs 15 light periods, then one heavy period, then 15 more light periods. A counter that is not cleared, or that compares against the wrong bound, would leave pulse-width mode there at a cycle the scoreboard does not expect. Every mode change is checked against a predicted cycle. A one-cycle slip, or an entry decided in the middle of a period rather than on the tick, is caught. The bench counts the exact cycle at which each gate may rise after the other falls, and checks it against the gap. It also drives a current-limit hit while pwm_cmp is still high, which exposes a high side that restarts inside the same period. In burst mode it holds all window flags low after the overshoot, which exposes a high side that re-arms without a new sag.

// File: rtl/buck_mode_pkg.sv
package buck_mode_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_PSV = 1'b1
  } mode_e;
endpackage

// File: rtl/buck_ll_mode.sv
module buck_ll_mode
  import buck_mode_pkg::*;
#(
  parameter int LL_CYCLES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pwm_tick,
  input  logic  pk_above,
  input  logic  ss_active,
  input  logic  v_below_lo,
  output mode_e mode
);
  localparam int CW = $clog2(LL_CYCLES + 1);

  logic [CW-1:0] ll_cnt;
  logic          heavy_seen;
  logic          heavy_eff;

  // the tick cycle itself still belongs to the period being closed
  assign heavy_eff = heavy_seen | pk_above;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= MODE_PWM;
      ll_cnt     <= '0;
      heavy_seen <= 1'b0;
    end else begin
      heavy_seen <= (pwm_tick || mode == MODE_PSV) ? 1'b0 : heavy_eff;
      case (mode)
        MODE_PWM: begin
          if (ss_active) begin
            ll_cnt <= '0;
          end else if (pwm_tick) begin
            if (heavy_eff) begin
              ll_cnt <= '0;
            end else if (ll_cnt == CW'(LL_CYCLES - 1)) begin
              ll_cnt <= '0;
              mode   <= MODE_PSV;
            end else begin
              ll_cnt <= ll_cnt + CW'(1);
            end
          end
        end
        default: begin
          if (v_below_lo || ss_active) begin
            mode   <= MODE_PWM;
            ll_cnt <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/buck_gate_req.sv
module buck_gate_req
  import buck_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mode_e mode,
  input  logic  pwm_tick,
  input  logic  pwm_cmp,
  input  logic  i_lim,
  input  logic  v_below_nom,
  input  logic  v_above_hi,
  input  logic  i_zero,
  output logic  hs_req,
  output logic  ls_req
);
  logic hs_n, ls_n;

  always_comb begin
    hs_n = hs_req;
    ls_n = ls_req;
    if (mode == MODE_PWM) begin
      if (pwm_tick) begin
        hs_n = pwm_cmp && !i_lim;
        ls_n = 1'b0;
      end else if (hs_req && (!pwm_cmp || i_lim)) begin
        hs_n = 1'b0;
        ls_n = 1'b1;
      end else if (ls_req && i_zero) begin
        ls_n = 1'b0;
      end
    end else begin
      if (hs_req) begin
        if (v_above_hi || i_lim) begin
          hs_n = 1'b0;
          ls_n = 1'b1;
        end
      end else if (v_below_nom && !v_above_hi && !i_lim) begin
        hs_n = 1'b1;
        ls_n = 1'b0;
      end else if (ls_req && i_zero) begin
        ls_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_req <= 1'b0;
      ls_req <= 1'b0;
    end else begin
      hs_req <= hs_n;
      ls_req <= ls_n;
    end
  end
endmodule

// File: rtl/buck_deadtime.sv
module buck_deadtime #(
  parameter int DEAD_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_req,
  input  logic ls_req,
  output logic hs_gate,
  output logic ls_gate
);
  generate
    if (DEAD_CYC == 0) begin : g_nogap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hs_gate <= 1'b0;
          ls_gate <= 1'b0;
        end else begin
          hs_gate <= hs_req && !ls_gate;
          ls_gate <= ls_req && !hs_req && !hs_gate;
        end
      end
    end else begin : g_gap
      localparam int DW = $clog2(DEAD_CYC + 1);
      logic [DW-1:0] off_cnt;
      logic          gap_ok;

      assign gap_ok = (off_cnt == DW'(DEAD_CYC)) && !hs_gate && !ls_gate;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          off_cnt <= '0;
          hs_gate <= 1'b0;
          ls_gate <= 1'b0;
        end else begin
          if (hs_gate || ls_gate)
            off_cnt <= '0;
          else if (off_cnt != DW'(DEAD_CYC))
            off_cnt <= off_cnt + DW'(1);
          hs_gate <= hs_gate ? hs_req : (hs_req && gap_ok);
          ls_gate <= ls_gate ? ls_req : (ls_req && !hs_req && gap_ok);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/buck_mode_ctrl.sv
module buck_mode_ctrl
  import buck_mode_pkg::*;
#(
  parameter int LL_CYCLES = 16,
  parameter int DEAD_CYC  = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_tick,
  input  logic pwm_cmp,
  input  logic pk_above,
  input  logic i_lim,
  input  logic v_below_nom,
  input  logic v_above_hi,
  input  logic v_below_lo,
  input  logic i_zero,
  input  logic ss_active,
  output logic hs_gate,
  output logic ls_gate,
  output logic mode_psv,
  output logic ilim_quarter
);
  mode_e mode;
  logic  hs_req, ls_req;

  buck_ll_mode #(.LL_CYCLES(LL_CYCLES)) u_mode (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .pk_above(pk_above),
    .ss_active(ss_active), .v_below_lo(v_below_lo), .mode(mode)
  );

  buck_gate_req u_req (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pwm_tick(pwm_tick),
    .pwm_cmp(pwm_cmp), .i_lim(i_lim), .v_below_nom(v_below_nom),
    .v_above_hi(v_above_hi), .i_zero(i_zero),
    .hs_req(hs_req), .ls_req(ls_req)
  );

  buck_deadtime #(.DEAD_CYC(DEAD_CYC)) u_dead (
    .clk(clk), .rst_n(rst_n), .hs_req(hs_req), .ls_req(ls_req),
    .hs_gate(hs_gate), .ls_gate(ls_gate)
  );

  assign mode_psv     = (mode == MODE_PSV);
  assign ilim_quarter = mode_psv;
endmodule

// File: rtl/buck_mode_ctrl_chk.sv
module buck_mode_ctrl_chk #(
  parameter int DEAD_CYC = 6
) (
  input logic clk,
  input logic rst_n,
  input logic pwm_tick,
  input logic ss_active,
  input logic v_below_lo,
  input logic i_lim,
  input logic hs_gate,
  input logic ls_gate,
  input logic mode_psv
);
  int unsigned lowc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lowc <= 0;
    else if (hs_gate || ls_gate)
      lowc <= 0;
    else if (lowc <= DEAD_CYC)
      lowc <= lowc + 1;
  end

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate && ls_gate));

  assert_gap_before_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hs_gate && !$past(hs_gate)) || (ls_gate && !$past(ls_gate)))
      |-> ($past(lowc) >= DEAD_CYC));

  assert_entry_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_psv) |-> ($past(pwm_tick) && !$past(ss_active)));

  assert_exit_on_sag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_psv && v_below_lo) |=> !mode_psv);

  assert_softstart_pwm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ss_active |=> !mode_psv);

  assert_limit_cuts_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    i_lim |=> ##1 !hs_gate);
endmodule

bind buck_mode_ctrl buck_mode_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) chk_i (.*);

// File: tb/buck_mode_ctrl_tb_top.sv
module buck_mode_ctrl_tb_top;
  localparam int LL   = 16;
  localparam int DEAD = 6;
  localparam int P    = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pwm_tick = 0, pwm_cmp = 0, pk_above = 0, i_lim = 0;
  logic v_below_nom = 0, v_above_hi = 0, v_below_lo = 0, i_zero = 0, ss_active = 0;
  logic hs_gate, ls_gate, mode_psv, ilim_quarter;

  buck_mode_ctrl #(.LL_CYCLES(LL), .DEAD_CYC(DEAD)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick), .pwm_cmp(pwm_cmp),
    .pk_above(pk_above), .i_lim(i_lim), .v_below_nom(v_below_nom),
    .v_above_hi(v_above_hi), .v_below_lo(v_below_lo), .i_zero(i_zero),
    .ss_active(ss_active), .hs_gate(hs_gate), .ls_gate(ls_gate),
    .mode_psv(mode_psv), .ilim_quarter(ilim_quarter)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    bit    mode;
    int    at;
    string tag;
  } exp_t;
  exp_t exp_q[$];
  exp_t e;

  int nchk = 0, nfail = 0;
  int ll = 0;
  bit prev_heavy = 0, mdl_psv = 0, done = 0;

  task automatic chk(input string tag, input bit ok, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  // driver-side model: predicts mode entries from the counting rule
  task automatic model_tick(input bit heavy_now);
    if (!mdl_psv) begin
      if (prev_heavy || ss_active) ll = 0;
      else begin
        ll++;
        if (ll == LL) begin
          ll = 0;
          mdl_psv = 1;
          exp_q.push_back('{1'b1, cyc + 1, "R2"});
        end
      end
    end
    prev_heavy = heavy_now;
  endtask

  task automatic pwm_period(input bit heavy, input int on_len);
    @(negedge clk);
    pwm_tick = 1; pwm_cmp = (on_len > 0);
    model_tick(heavy);
    for (int i = 1; i < P; i++) begin
      @(negedge clk);
      pwm_tick = 0;
      pk_above = heavy && (i == 2);
      pwm_cmp  = (i < on_len);
    end
  endtask

  task automatic wait_gate(input bit ls_sel, input string tag);
    int n = 0;
    while (((ls_sel ? ls_gate : hs_gate) !== 1'b1) && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk(tag, (ls_sel ? ls_gate : hs_gate) === 1'b1, ls_sel ? ls_gate : hs_gate, 1);
  endtask

  task automatic go_return(input string tag);
    mdl_psv = 0; ll = 0; prev_heavy = 0;
    exp_q.push_back('{1'b0, cyc + 1, tag});
  endtask

  // scoreboard monitor: mode changes and gate spacing
  bit last_mode = 0, last_hs = 0, last_ls = 0;
  int lowc = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mode_psv !== last_mode) begin
        if (exp_q.size() == 0) chk("R2", 0, mode_psv, last_mode);
        else begin
          e = exp_q.pop_front();
          chk(e.tag, (mode_psv === e.mode) && (cyc == e.at), cyc, e.at);
        end
      end
      if (hs_gate && ls_gate) chk("R8", 0, 1, 0);
      if ((hs_gate && !last_hs) || (ls_gate && !last_ls))
        chk("R8", lowc >= DEAD, lowc, DEAD);
      lowc      = (hs_gate || ls_gate) ? 0 : lowc + 1;
      last_mode = mode_psv;
      last_hs   = hs_gate;
      last_ls   = ls_gate;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R7 watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", hs_gate === 1'b0, hs_gate, 0);
    chk("R1", ls_gate === 1'b0, ls_gate, 0);
    chk("R1", mode_psv === 1'b0, mode_psv, 0);
    chk("R1", ilim_quarter === 1'b0, ilim_quarter, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    repeat (3) pwm_period(1, 8);

    // R7/R8: exact gate timing in a continuous-conduction period
    @(negedge clk); pwm_tick = 1; pwm_cmp = 1; model_tick(1);
    @(negedge clk); pwm_tick = 0; pk_above = 1;
    @(negedge clk); pk_above = 0;
    chk("R7", ls_gate === 1'b0, ls_gate, 0);
    chk("R8", hs_gate === 1'b0, hs_gate, 0);
    repeat (DEAD) @(negedge clk);
    chk("R8", hs_gate === 1'b0, hs_gate, 0);
    @(negedge clk);
    chk("R7", hs_gate === 1'b1, hs_gate, 1);
    repeat (3) @(negedge clk);
    pwm_cmp = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R7", hs_gate === 1'b0, hs_gate, 0);
    repeat (DEAD) @(negedge clk);
    chk("R8", ls_gate === 1'b0, ls_gate, 0);
    @(negedge clk);
    chk("R7", ls_gate === 1'b1, ls_gate, 1);
    i_zero = 1;
    @(negedge clk); i_zero = 0;
    @(negedge clk);
    chk("R7", ls_gate === 1'b0, ls_gate, 0);

    // R9: current limit ends the pulse for the rest of the period
    @(negedge clk); pwm_tick = 1; pwm_cmp = 1; model_tick(1);
    @(negedge clk); pwm_tick = 0; pk_above = 1;
    @(negedge clk); pk_above = 0;
    wait_gate(0, "R7");
    i_lim = 1;
    @(negedge clk); i_lim = 0;
    @(negedge clk);
    chk("R9", hs_gate === 1'b0, hs_gate, 0);
    repeat (5) @(negedge clk);
    chk("R9", hs_gate === 1'b0, hs_gate, 0);
    pwm_cmp = 0;
    repeat (4) @(negedge clk);

    // R3: 15 light, one heavy, 15 light: no entry
    repeat (15) pwm_period(0, 8);
    pwm_period(1, 8);
    repeat (15) pwm_period(0, 8);
    chk("R3", mode_psv === 1'b0, mode_psv, 0);

    // R2: continue light until the 16th consecutive light period
    for (int g = 0; g < 40 && !mdl_psv; g++) pwm_period(0, 8);
    chk("R2", mode_psv === 1'b1, mode_psv, 1);
    chk("R6", ilim_quarter === 1'b1, ilim_quarter, 1);

    // R10: window regulation in burst mode
    @(negedge clk); v_above_hi = 1;
    @(negedge clk); v_above_hi = 0;
    repeat (DEAD + 4) @(negedge clk);
    i_zero = 1;
    @(negedge clk); i_zero = 0;
    repeat (3) @(negedge clk);
    chk("R10", hs_gate === 1'b0, hs_gate, 0);
    chk("R10", ls_gate === 1'b0, ls_gate, 0);
    v_below_nom = 1;
    wait_gate(0, "R10");
    v_below_nom = 0;
    repeat (3) @(negedge clk);
    chk("R10", hs_gate === 1'b1, hs_gate, 1);
    v_above_hi = 1;
    @(negedge clk); v_above_hi = 0;
    @(negedge clk);
    chk("R10", hs_gate === 1'b0, hs_gate, 0);
    wait_gate(1, "R10");
    repeat (8) @(negedge clk);
    chk("R10", hs_gate === 1'b0, hs_gate, 0);
    i_zero = 1;
    @(negedge clk); i_zero = 0;
    @(negedge clk);
    chk("R10", ls_gate === 1'b0, ls_gate, 0);
    chk("R10", mode_psv === 1'b1, mode_psv, 1);

    // R5: sag below the lower threshold returns to pulse-width mode
    @(negedge clk); v_below_lo = 1; go_return("R5");
    @(negedge clk); v_below_lo = 0;
    @(negedge clk);
    chk("R5", mode_psv === 1'b0, mode_psv, 0);
    chk("R6", ilim_quarter === 1'b0, ilim_quarter, 0);

    // R4: soft-start blocks entry, then forces exit
    pwm_period(1, 8);
    ss_active = 1;
    repeat (20) pwm_period(0, 8);
    chk("R4", mode_psv === 1'b0, mode_psv, 0);
    ss_active = 0;
    for (int g = 0; g < 40 && !mdl_psv; g++) pwm_period(0, 8);
    chk("R2", mode_psv === 1'b1, mode_psv, 1);
    @(negedge clk); ss_active = 1; go_return("R4");
    @(negedge clk);
    @(negedge clk);
    chk("R4", mode_psv === 1'b0, mode_psv, 0);
    ss_active = 0;

    repeat (5) @(negedge clk);
    chk("R2", exp_q.size() == 0, exp_q.size(), 0);
    finish_run();
  end
endmodule